// File: doc/BRIEF.md
# FM Synthesizer Timer and Interrupt Status Unit

This block provides the interval-timer and interrupt section of an FM sound generator. A host reaches it through a two-step port. It first writes a register index on the address strobe, then writes a value on the data strobe. A bank input picks one of two port pairs. Only the left pair decodes the timer registers. Right-pair accesses are accepted and have no effect here.

There are two 8-bit up-counting timers. Each one advances on its own tick, and the ticks come from a prescaler on the system clock. By default the tick periods are 80 us and 320 us. The host loads a preset of 256 minus the wanted tick count. A running timer that steps past 255 reloads its preset and keeps counting. An unmasked overflow latches that timer's flag and raises the summary interrupt. A control write with the top bit set clears every flag and leaves the timers and the control state as they were. The host reads a status byte at any time. It carries the summary flag, the two timer flags and a fixed variant code in the low bits.

Top module: `fm_timer_unit`

## Requirements
- R1: After reset, status_o reads 0x06: bits 7..5 are zero and bits 4..0 carry the variant code 0x06. irq_o is low.
- R2: A left-bank address write stores an index. Each later left-bank data write goes to the register that index names: 0x02 is the timer 1 preset, 0x03 is the timer 2 preset and 0x04 is control. The index persists across data writes. Other indices are ignored.
- R3: Writes with bank_i=1 change neither the left index nor any timer register.
- R4: Timer 1 advances once per T1_US microseconds of clock. Started from preset p, it overflows after 256-p ticks and sets status bit 6.
- R5: Timer 2 advances once per T2_US microseconds and sets status bit 5 on an unmasked overflow, no earlier than 256-p ticks after start.
- R6: Control bits: bit 0 starts timer 1, bit 1 starts timer 2, bit 6 masks timer 1 and bit 5 masks timer 2.
- R7: On overflow a running timer reloads its preset and continues, so overflows repeat every 256-p ticks.
- R8: A masked timer keeps counting but never sets its flag or the summary bit. Unmasking it later raises no flag for past overflows.
- R9: A control write with bit 7 set clears all flags and drops irq_o. It leaves the start and mask state and the counts unchanged.
- R10: If an unmasked overflow falls in the same cycle as a flag-clear command, the flag of that overflow is set after the cycle.
- R11: irq_o and status bit 7 both equal the OR of the two timer flags.
- R12: A stopped timer holds its count and raises no flag. Starting it again reloads the preset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one cycle per access |
| bank_i | input | 1 | Port pair select: 0 left, 1 right |
| sel_data_i | input | 1 | 0 selects the address port, 1 selects the data port |
| wdata_i | input | 8 | Index or data byte |
| status_o | output | 8 | {summary, timer 1 flag, timer 2 flag, variant code} |
| irq_o | output | 1 | Interrupt, active high |

## Verification
Two events can fall in the same cycle: a timer overflow that latches a flag, and a control write that clears the flags. The bench reads its reference model to find the cycle just before a predicted timer 1 overflow. It issues the clear write in exactly that cycle and expects the flag and the summary bit to stay set. It then places the same clear write in a cycle with no overflow and expects all three top status bits to drop to zero. The model is compared with the status byte and the interrupt on every clock throughout both cases.

// File: rtl/fm_tmr_pkg.sv
package fm_tmr_pkg;
  localparam logic [7:0] IDX_PRE1 = 8'h02;
  localparam logic [7:0] IDX_PRE2 = 8'h03;
  localparam logic [7:0] IDX_CTRL = 8'h04;
  localparam int unsigned CB_CLR  = 7;
  localparam int unsigned CB_MSK1 = 6;
  localparam int unsigned CB_MSK2 = 5;
  localparam int unsigned CB_RUN2 = 1;
  localparam int unsigned CB_RUN1 = 0;
  localparam int unsigned N_TMR   = 2;
endpackage

// File: rtl/fm_tick_gen.sv
module fm_tick_gen #(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned PERIOD_US = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CYC_US = CLK_HZ / 1_000_000;
  localparam int unsigned DIV_RAW = CYC_US * PERIOD_US;
  localparam int unsigned DIV = (DIV_RAW < 1) ? 1 : DIV_RAW;
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt_q;

  assign tick_o = (cnt_q == W'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R4
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((DIV > 1) && tick_o) |=> !tick_o);
endmodule

// File: rtl/fm_preset_timer.sv
module fm_preset_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] preset_i,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  // a start edge loads the preset and takes no tick in that cycle
  assign ovf_o = run_i && run_q && tick_i && (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= run_i;
      if (run_i && !run_q)     cnt_q <= preset_i;
      else if (run_i && tick_i) cnt_q <= (cnt_q == '1) ? preset_i : cnt_q + 1'b1;
    end
  end

  // R7
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (cnt_q == $past(preset_i)));

  // R12
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_q));
endmodule

// File: rtl/fm_timer_unit.sv
module fm_timer_unit
  import fm_tmr_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned T1_US      = 80,
  parameter int unsigned T2_US      = 320,
  parameter logic [4:0]  VARIANT_ID = 5'h06
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       bank_i,
  input  logic       sel_data_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] status_o,
  output logic       irq_o
);
  logic [7:0]            idx_q;
  logic [N_TMR-1:0][7:0] preset_q;
  logic [N_TMR-1:0]      start_q, mask_q, flag_q, tick, ovf;
  logic                  wr_addr, wr_data, ctrl_wr, clr_cmd;

  assign wr_addr = wr_i && !bank_i && !sel_data_i;
  assign wr_data = wr_i && !bank_i && sel_data_i;
  assign ctrl_wr = wr_data && (idx_q == IDX_CTRL);
  assign clr_cmd = ctrl_wr && wdata_i[CB_CLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      preset_q <= '0;
      start_q  <= '0;
      mask_q   <= '0;
    end else begin
      if (wr_addr) idx_q <= wdata_i;
      if (wr_data && idx_q == IDX_PRE1) preset_q[0] <= wdata_i;
      if (wr_data && idx_q == IDX_PRE2) preset_q[1] <= wdata_i;
      if (ctrl_wr && !wdata_i[CB_CLR]) begin
        start_q <= {wdata_i[CB_RUN2], wdata_i[CB_RUN1]};
        mask_q  <= {wdata_i[CB_MSK2], wdata_i[CB_MSK1]};
      end
    end
  end

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    localparam int unsigned PER_US = (g == 0) ? T1_US : T2_US;

    fm_tick_gen #(.CLK_HZ(CLK_HZ), .PERIOD_US(PER_US)) u_tick (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_o(tick[g])
    );

    fm_preset_timer #(.CNT_W(8)) u_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (start_q[g]),
      .tick_i  (tick[g]),
      .preset_i(preset_q[g]),
      .ovf_o   (ovf[g])
    );

    // overflow wins over a clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     flag_q[g] <= 1'b0;
      else if (ovf[g] && !mask_q[g])   flag_q[g] <= 1'b1;
      else if (clr_cmd)                flag_q[g] <= 1'b0;
    end
  end

  assign irq_o    = |flag_q;
  assign status_o = {irq_o, flag_q[0], flag_q[1], VARIANT_ID};

  // R9
  clr_drops_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_cmd && !(|ovf)) |=> !irq_o);

  // R8
  masked_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf[0] && mask_q[0] && !flag_q[0] && !clr_cmd) |=> !flag_q[0]);

  // R10
  ovf_beats_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_cmd && ovf[0] && !mask_q[0]) |=> flag_q[0]);

  // R3
  right_bank_inert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && bank_i) |=> ($stable(idx_q) && $stable(preset_q) && $stable(start_q)
                          && $stable(mask_q)));
endmodule

// File: tb/fm_timer_unit_tb_top.sv
module fm_timer_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int P1 = 2;
  localparam int P2 = 8;

  logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0, bank = 1'b0, sel = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] status;
  logic irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  fm_timer_unit #(.CLK_HZ(1_000_000), .T1_US(2), .T2_US(8), .VARIANT_ID(5'h06)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .bank_i(bank), .sel_data_i(sel),
    .wdata_i(wdata), .status_o(status), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  string req_tag = "R1";
  bit done = 1'b0;

  int m_idx;
  int m_pre[2], m_cnt[2], m_pc[2];
  bit m_st[2], m_mk[2], m_rq[2], m_fl[2];

  task automatic chk(bit ok, string r, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", r, cyc, act, exp);
    end
  endtask

  function automatic int per(int k);
    return (k == 0) ? P1 : P2;
  endfunction

  function automatic bit pred_ovf(int k);
    return m_st[k] && m_rq[k] && (m_pc[k] == per(k) - 1) && (m_cnt[k] == 255);
  endfunction

  // reference model, updated on each edge, compared just after it
  always @(posedge clk) begin : model
    bit tk[2];
    bit ov[2];
    bit clr;
    logic [7:0] exp;
    cyc++;
    if (!rst_n) begin
      m_idx = 0;
      for (int k = 0; k < 2; k++) begin
        m_pre[k] = 0; m_cnt[k] = 0; m_pc[k] = 0;
        m_st[k] = 0; m_mk[k] = 0; m_rq[k] = 0; m_fl[k] = 0;
      end
    end else begin
      for (int k = 0; k < 2; k++) begin
        tk[k] = (m_pc[k] == per(k) - 1);
        ov[k] = m_st[k] && m_rq[k] && tk[k] && (m_cnt[k] == 255);
      end
      clr = wr && sel && !bank && (m_idx == 4) && wdata[7];
      for (int k = 0; k < 2; k++) begin
        if (m_st[k] && !m_rq[k]) m_cnt[k] = m_pre[k];
        else if (m_st[k] && tk[k]) m_cnt[k] = (m_cnt[k] == 255) ? m_pre[k] : m_cnt[k] + 1;
        m_rq[k] = m_st[k];
        m_pc[k] = tk[k] ? 0 : m_pc[k] + 1;
        if (clr) m_fl[k] = 0;
        if (ov[k] && !m_mk[k]) m_fl[k] = 1;
      end
      if (wr && !bank && !sel) m_idx = int'(wdata);
      else if (wr && !bank && sel) begin
        if (m_idx == 2) m_pre[0] = int'(wdata);
        else if (m_idx == 3) m_pre[1] = int'(wdata);
        else if (m_idx == 4 && !wdata[7]) begin
          m_st[0] = wdata[0]; m_st[1] = wdata[1];
          m_mk[0] = wdata[6]; m_mk[1] = wdata[5];
        end
      end
    end
    #1;
    if (rst_n && !done) begin
      exp = {m_fl[0] | m_fl[1], m_fl[0], m_fl[1], 5'h06};
      chk(status === exp, req_tag, status, exp);
      // R11
      chk(irq === status[7] && irq === (m_fl[0] | m_fl[1]), "R11", {7'd0, irq}, {7'd0, exp[7]});
    end
  end

  task automatic wr_cyc(bit b, bit s, logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; bank = b; sel = s; wdata = d;
    @(negedge clk);
    wr = 1'b0; bank = 1'b0; sel = 1'b0;
  endtask

  task automatic reg_wr(logic [7:0] idx, logic [7:0] val);
    wr_cyc(1'b0, 1'b0, idx);
    wr_cyc(1'b0, 1'b1, val);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic top3(logic [2:0] e, string r);
    chk(status[7:5] === e, r, {5'd0, status[7:5]}, {5'd0, e});
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : stim
    int t0, t1;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1
    chk(status === 8'h06, "R1", status, 8'h06);
    chk(irq === 1'b0, "R1", {7'd0, irq}, 8'h00);

    req_tag = "R4";
    reg_wr(8'h02, 8'hFF);
    reg_wr(8'h04, 8'h21);
    idle(8);
    top3(3'b110, "R4");
    top3(3'b110, "R6");

    req_tag = "R9";
    reg_wr(8'h04, 8'h60);
    wr_cyc(1'b0, 1'b1, 8'h80);
    top3(3'b000, "R9");
    req_tag = "R12";
    idle(20);
    top3(3'b000, "R12");

    req_tag = "R8";
    reg_wr(8'h04, 8'h41);
    idle(20);
    top3(3'b000, "R8");
    wr_cyc(1'b0, 1'b1, 8'h00);
    idle(4);
    top3(3'b000, "R8");

    req_tag = "R5";
    reg_wr(8'h03, 8'hFE);
    reg_wr(8'h04, 8'h42);
    idle(6);
    top3(3'b000, "R5");
    idle(30);
    top3(3'b101, "R5");
    reg_wr(8'h04, 8'h60);
    wr_cyc(1'b0, 1'b1, 8'h80);
    top3(3'b000, "R9");

    req_tag = "R7";
    reg_wr(8'h02, 8'hFC);
    reg_wr(8'h04, 8'h21);
    do @(negedge clk); while (!status[6]);
    t0 = cyc;
    wr_cyc(1'b0, 1'b1, 8'h80);
    do @(negedge clk); while (!status[6]);
    t1 = cyc;
    chk((t1 - t0) == 4 * P1, "R7", 8'(t1 - t0), 8'(4 * P1));
    reg_wr(8'h04, 8'h60);
    wr_cyc(1'b0, 1'b1, 8'h80);

    req_tag = "R3";
    reg_wr(8'h02, 8'hFF);
    wr_cyc(1'b0, 1'b0, 8'h04);
    wr_cyc(1'b1, 1'b1, 8'h21);
    idle(20);
    top3(3'b000, "R3");
    wr_cyc(1'b1, 1'b0, 8'h02);
    wr_cyc(1'b0, 1'b1, 8'h21);
    idle(8);
    top3(3'b110, "R2");

    req_tag = "R10";
    do @(negedge clk); while (!pred_ovf(0));
    wr = 1'b1; bank = 1'b0; sel = 1'b1; wdata = 8'h80;
    @(negedge clk);
    wr = 1'b0; sel = 1'b0;
    top3(3'b110, "R10");
    do @(negedge clk); while (pred_ovf(0) || pred_ovf(1));
    wr = 1'b1; bank = 1'b0; sel = 1'b1; wdata = 8'h80;
    @(negedge clk);
    wr = 1'b0; sel = 1'b0;
    top3(3'b000, "R9");
    idle(4);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule